// File: doc/BRIEF.md
# Banked Interrupt Vector Controller

This block gathers 72 level-sensitive interrupt lines and turns them into one vector number for the processor. Sixty-four peripheral lines are split into two 32-bit banks, and eight core lines form a small third bank. Each line has an enable bit. Software changes the enable bits in three ways: a write-one-to-set register per bank, a write-one-to-clear register per bank, and a per-vector enable/disable command port that rejects vector numbers beyond the last source.

Enabled lines are combined into a basic summary word. From low bit to high, this word holds the eight core lines, one "any pending" flag for each peripheral bank, and direct copies of eleven frequently used peripheral lines. The vector encoder first resolves through the core and copied bits of this word. Only when none of them is pending does it scan bank 1, and then bank 2. The vector and its valid flag are registered. Software can also read back the enable words and the pending words, and these reads are registered as well.

Top module: `irq_vector_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, all enable bits clear, `vec_valid` goes low, `vec_id` becomes 255 and `rd_data` becomes 0.
- R2: A write with `wr_addr[2]`=0 sets the enable bits marked by ones in `wr_data`. `wr_addr[1:0]` selects the bank: 0 is bank 1, 1 is bank 2, 2 is the core bank. Bits written as zero keep their value.
- R3: A write with `wr_addr[2]`=1 clears the enable bits marked by ones in `wr_data`, using the same bank selection as R2. Bits written as zero keep their value.
- R4: A command with `cmd_valid`=1 and `cmd_vector` at most 71 sets the enable of that vector when `cmd_enable`=1 and clears it when `cmd_enable`=0. `cmd_vector[7:5]` selects the bank and `cmd_vector[4:0]` selects the bit. A command with `cmd_vector` above 71 changes nothing.
- R5: A line counts as pending only when its enable bit is set. A disabled line never produces a vector.
- R6: A pending core line i (0..7) has the highest priority and gives vector 64+i. Among core lines, the lowest index wins.
- R7: When no core line is pending, the copied peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62 come next, with priority in that listed order. They win over every other bank line, including lower-numbered ones.
- R8: When no line from R6 or R7 is pending, the lowest pending bank 1 line n gives vector n. Failing that, the lowest pending bank 2 line gives 32 plus its index within the bank.
- R9: With nothing pending, `vec_id`=255 and `vec_valid`=0. Whenever `vec_valid`=1, `vec_id` is at most 71.
- R10: `vec_id` and `vec_valid` reflect the sources and enables present at the previous clock edge.
- R11: `rd_data` is registered and returns the word selected by `rd_addr`. Addresses 0, 1 and 2 return the enables of bank 1, bank 2 and the core bank. Address 4 returns bank 1 pending and address 5 returns bank 2 pending. Address 6 returns the basic word: bits 0-7 are the core lines, bit 8 is "any bank 1 pending", bit 9 is "any bank 2 pending", and bits 10-20 are the R7 lines in the R7 order. Unused bits and addresses 3 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_periph | input | 64 | Peripheral lines; bits 31:0 are bank 1, bits 63:32 are bank 2 |
| src_core | input | 8 | Core lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: bit 2 selects clear, bits 1:0 select the bank |
| wr_data | input | 32 | Write data, one bit per source |
| cmd_valid | input | 1 | Per-vector command strobe |
| cmd_enable | input | 1 | 1 = enable, 0 = disable |
| cmd_vector | input | 8 | Vector number the command acts on |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Registered read data |
| vec_id | output | 8 | Registered winning vector, 255 when idle |
| vec_valid | output | 1 | Registered flag: a vector is pending |

## Verification
Source patterns are chosen so that each one tells a single priority step apart from its neighbours. A core line is raised together with a copied line, to show core priority. A copied line is paired with a lower-numbered plain bank 1 line, such as line 53 against line 0 and line 7 against line 3, to show that the copied lines win. Bank 1 lines are raised against bank 2 lines, and bank 2 lines appear alone, to show the ordering at the end of the scan. Disabled lines are driven high to show the masking, and a change on a source is sampled just before and just after the next edge to show the single register stage. The pending read-back of the basic word is checked against a hand-built layout of core, summary and copied bits.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int BANK_W     = 32;
  localparam int CORE_N     = 8;
  localparam int NUM_BANK   = 3;
  localparam int SC_N       = 11;
  localparam int BASIC_W    = CORE_N + 2 + SC_N;
  localparam int VEC_W      = 8;
  localparam int CORE_BASE  = 2 * BANK_W;
  localparam int MAX_VEC    = CORE_BASE + CORE_N - 1;
  localparam int NONE_VEC   = 255;
  localparam logic [BASIC_W-1:0] BASIC_MASK = 21'h1FFCFF;

  // peripheral line copied into basic bit CORE_N+2+k
  function automatic int sc_line(input int k);
    case (k)
      0: sc_line = 7;   1: sc_line = 9;   2: sc_line = 10;  3: sc_line = 18;
      4: sc_line = 19;  5: sc_line = 53;  6: sc_line = 54;  7: sc_line = 55;
      8: sc_line = 56;  9: sc_line = 57;  default: sc_line = 62;
    endcase
  endfunction

  function automatic logic [4:0] lowest32(input logic [31:0] v);
    lowest32 = '0;
    for (int i = 31; i >= 0; i--)
      if (v[i]) lowest32 = 5'(i);
  endfunction
endpackage

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_m,
  input  logic [W-1:0] clr_m,
  output logic [W-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= (en_q & ~clr_m) | set_m;
  end
endmodule

// File: rtl/irq_basic_word.sv
module irq_basic_word
  import irq_vec_pkg::*;
(
  input  logic [BANK_W-1:0]  pend1,
  input  logic [BANK_W-1:0]  pend2,
  input  logic [CORE_N-1:0]  pendc,
  output logic [BASIC_W-1:0] basic
);
  logic [2*BANK_W-1:0] pend_all;
  assign pend_all = {pend2, pend1};

  assign basic[CORE_N-1:0] = pendc;
  assign basic[CORE_N]     = |pend1;
  assign basic[CORE_N+1]   = |pend2;

  for (genvar k = 0; k < SC_N; k++) begin : g_sc
    localparam int LINE = sc_line(k);
    assign basic[CORE_N+2+k] = pend_all[LINE];
  end
endmodule

// File: rtl/irq_vec_enc.sv
module irq_vec_enc
  import irq_vec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [BASIC_W-1:0] basic,
  input  logic [BANK_W-1:0]  pend1,
  input  logic [BANK_W-1:0]  pend2,
  output logic [VEC_W-1:0]   vec_id,
  output logic               vec_valid
);
  logic [BASIC_W-1:0] masked;
  logic [4:0]         idx;
  logic [VEC_W-1:0]   nxt_id;
  logic               nxt_v;

  assign masked = basic & BASIC_MASK;

  always_comb begin
    nxt_id = VEC_W'(NONE_VEC);
    nxt_v  = 1'b0;
    idx    = lowest32(32'(masked));
    if (|masked) begin
      nxt_v = 1'b1;
      if (int'(idx) < CORE_N)
        nxt_id = VEC_W'(CORE_BASE) + VEC_W'(idx);
      else if (int'(idx) == CORE_N)
        nxt_id = VEC_W'(lowest32(pend1));
      else if (int'(idx) == CORE_N + 1)
        nxt_id = VEC_W'(BANK_W) + VEC_W'(lowest32(pend2));
      else
        nxt_id = VEC_W'(sc_line(int'(idx) - CORE_N - 2));
    end else if (|pend1) begin
      nxt_v  = 1'b1;
      nxt_id = VEC_W'(lowest32(pend1));
    end else if (|pend2) begin
      nxt_v  = 1'b1;
      nxt_id = VEC_W'(BANK_W) + VEC_W'(lowest32(pend2));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_id    <= VEC_W'(NONE_VEC);
      vec_valid <= 1'b0;
    end else begin
      vec_id    <= nxt_id;
      vec_valid <= nxt_v;
    end
  end
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
  import irq_vec_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [2*BANK_W-1:0] src_periph,
  input  logic [CORE_N-1:0]   src_core,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [BANK_W-1:0]   wr_data,
  input  logic                cmd_valid,
  input  logic                cmd_enable,
  input  logic [VEC_W-1:0]    cmd_vector,
  input  logic [2:0]          rd_addr,
  output logic [BANK_W-1:0]   rd_data,
  output logic [VEC_W-1:0]    vec_id,
  output logic                vec_valid
);
  logic [NUM_BANK-1:0][BANK_W-1:0] en_w;
  logic [BANK_W-1:0]  en_b1, en_b2, en_core;
  logic [BANK_W-1:0]  pend1, pend2;
  logic [CORE_N-1:0]  pendc;
  logic [BASIC_W-1:0] basic;
  logic               cmd_ok;

  assign cmd_ok = cmd_valid && (int'(cmd_vector) <= MAX_VEC);

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    localparam int W = (b < 2) ? BANK_W : CORE_N;
    logic         wr_hit, cmd_hit;
    logic [W-1:0] bitsel, set_m, clr_m, q;
    assign wr_hit  = wr_en && (wr_addr[1:0] == 2'(b));
    assign cmd_hit = cmd_ok && (int'(cmd_vector[7:5]) == b);
    assign bitsel  = W'(1) << cmd_vector[4:0];
    assign set_m   = ((wr_hit && !wr_addr[2]) ? wr_data[W-1:0] : '0)
                   | ((cmd_hit &&  cmd_enable) ? bitsel : '0);
    assign clr_m   = ((wr_hit &&  wr_addr[2]) ? wr_data[W-1:0] : '0)
                   | ((cmd_hit && !cmd_enable) ? bitsel : '0);
    irq_en_bank #(.W(W)) u_en (
      .clk(clk), .rst(rst), .set_m(set_m), .clr_m(clr_m), .en_q(q)
    );
    assign en_w[b] = BANK_W'(q);
  end

  assign en_b1   = en_w[0];
  assign en_b2   = en_w[1];
  assign en_core = en_w[2];

  assign pend1 = src_periph[BANK_W-1:0] & en_b1;
  assign pend2 = src_periph[2*BANK_W-1:BANK_W] & en_b2;
  assign pendc = src_core & en_core[CORE_N-1:0];

  irq_basic_word u_basic (
    .pend1(pend1), .pend2(pend2), .pendc(pendc), .basic(basic)
  );

  irq_vec_enc u_enc (
    .clk(clk), .rst(rst), .basic(basic), .pend1(pend1), .pend2(pend2),
    .vec_id(vec_id), .vec_valid(vec_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        3'd0:    rd_data <= en_b1;
        3'd1:    rd_data <= en_b2;
        3'd2:    rd_data <= en_core;
        3'd4:    rd_data <= pend1;
        3'd5:    rd_data <= pend2;
        3'd6:    rd_data <= BANK_W'(basic);
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_ctl_chk.sv
module irq_vector_ctl_chk (
  input logic        clk,
  input logic        rst,
  input logic [63:0] src_periph,
  input logic [7:0]  src_core,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        cmd_valid,
  input logic [7:0]  cmd_vector,
  input logic [31:0] en_b1,
  input logic [31:0] en_b2,
  input logic [31:0] en_core,
  input logic [7:0]  vec_id,
  input logic        vec_valid
);
  logic any_pend, core_pend;
  assign core_pend = |(src_core & en_core[7:0]);
  assign any_pend  = core_pend | (|(src_periph[31:0] & en_b1))
                   | (|(src_periph[63:32] & en_b2));

  a_r1_reset: assert property (@(posedge clk)
    rst |=> (en_b1 == 0 && en_b2 == 0 && en_core == 0 && !vec_valid && vec_id == 8'd255));

  a_r2_set_bank1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd0) |=> ((en_b1 & $past(wr_data)) == $past(wr_data)));

  a_r3_clr_bank2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd5 && !cmd_valid) |=> ((en_b2 & $past(wr_data)) == 0));

  a_r4_reject: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_vector > 8'd71 && !wr_en) |=>
      ($stable(en_b1) && $stable(en_b2) && $stable(en_core)));

  a_r6_core_first: assert property (@(posedge clk) disable iff (rst)
    core_pend |=> (vec_valid && vec_id >= 8'd64));

  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    !any_pend |=> (!vec_valid && vec_id == 8'd255));

  a_r9_range: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_id <= 8'd71));

  a_r10_valid_next: assert property (@(posedge clk) disable iff (rst)
    any_pend |=> vec_valid);
endmodule

bind irq_vector_ctl irq_vector_ctl_chk u_chk (
  .clk(clk), .rst(rst), .src_periph(src_periph), .src_core(src_core),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cmd_valid(cmd_valid), .cmd_vector(cmd_vector),
  .en_b1(en_b1), .en_b2(en_b2), .en_core(en_core),
  .vec_id(vec_id), .vec_valid(vec_valid)
);

// File: tb/irq_vector_ctl_bench.sv
module irq_vector_ctl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] src_periph;
  logic [7:0]  src_core;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        cmd_valid, cmd_enable;
  logic [7:0]  cmd_vector;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic [7:0]  vec_id;
  logic        vec_valid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_vector_ctl u_irq_vector_ctl (
    .clk(clk), .rst(rst), .src_periph(src_periph), .src_core(src_core),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_enable(cmd_enable), .cmd_vector(cmd_vector),
    .rd_addr(rd_addr), .rd_data(rd_data), .vec_id(vec_id), .vec_valid(vec_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_cmd(input logic en, input logic [7:0] v);
    cmd_valid = 1'b1; cmd_enable = en; cmd_vector = v;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a;
    @(negedge clk);
    chk(req, rd_data, exp);
  endtask

  task automatic vec_check(input string req, input logic [63:0] p, input logic [7:0] c,
                           input logic [7:0] exp_id, input logic exp_v);
    src_periph = p; src_core = c;
    @(negedge clk);
    chk(req, {23'd0, vec_valid, vec_id}, {23'd0, exp_v, exp_id});
  endtask

  task automatic enable_all();
    do_write(3'd0, 32'hFFFF_FFFF);
    do_write(3'd1, 32'hFFFF_FFFF);
    do_write(3'd2, 32'hFFFF_FFFF);
  endtask

  task automatic disable_all();
    do_write(3'd4, 32'hFFFF_FFFF);
    do_write(3'd5, 32'hFFFF_FFFF);
    do_write(3'd6, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    chk("R1 vec", {23'd0, vec_valid, vec_id}, {23'd0, 1'b0, 8'd255});
    chk("R1 rd_data", rd_data, 32'd0);
    rd_check("R1 en bank1", 3'd0, 32'd0);
    rd_check("R1 en core", 3'd2, 32'd0);
  endtask

  task automatic t_write_regs();
    do_write(3'd0, 32'hA5A5_0000);
    do_write(3'd0, 32'h0000_00FF);
    rd_check("R2 set keeps zeros", 3'd0, 32'hA5A5_00FF);
    do_write(3'd4, 32'h0000_000F);
    rd_check("R3 clear keeps zeros", 3'd0, 32'hA5A5_00F0);
    do_write(3'd2, 32'hFFFF_FFFF);
    rd_check("R11 core unused bits", 3'd2, 32'h0000_00FF);
    rd_check("R11 addr 3 zero", 3'd3, 32'd0);
    disable_all();
    rd_check("R3 clear all bank1", 3'd0, 32'd0);
  endtask

  task automatic t_cmd();
    do_cmd(1'b1, 8'd40);
    rd_check("R4 enable v40", 3'd1, 32'h0000_0100);
    do_cmd(1'b1, 8'd71);
    rd_check("R4 enable v71", 3'd2, 32'h0000_0080);
    do_cmd(1'b1, 8'd72);
    rd_check("R4 reject v72 bank1", 3'd0, 32'd0);
    rd_check("R4 reject v72 bank2", 3'd1, 32'h0000_0100);
    rd_check("R4 reject v72 core", 3'd2, 32'h0000_0080);
    do_cmd(1'b0, 8'd200);
    rd_check("R4 reject disable v200", 3'd2, 32'h0000_0080);
    do_cmd(1'b0, 8'd40);
    rd_check("R4 disable v40", 3'd1, 32'd0);
    do_cmd(1'b0, 8'd71);
  endtask

  task automatic t_priority();
    enable_all();
    vec_check("R8 bank1 over bank2", 64'h2_0000_0008, 8'h00, 8'd3, 1'b1);
    vec_check("R8 bank2 alone", 64'h2_0000_0000, 8'h00, 8'd33, 1'b1);
    vec_check("R8 bank1 31 over bank2", 64'h2_8000_0000, 8'h00, 8'd31, 1'b1);
    vec_check("R7 line53 over line0", 64'h0020_0000_0000_0001, 8'h00, 8'd53, 1'b1);
    vec_check("R7 line7 over line3", 64'h0000_0000_0000_0088, 8'h00, 8'd7, 1'b1);
    vec_check("R7 order 62 vs 18", 64'h4000_0000_0004_0000, 8'h00, 8'd18, 1'b1);
    vec_check("R6 core over shortcut", 64'h0000_0000_0000_0080, 8'h60, 8'd69, 1'b1);
    vec_check("R6 core lowest", 64'd0, 8'h81, 8'd64, 1'b1);
    vec_check("R9 idle", 64'd0, 8'h00, 8'd255, 1'b0);
  endtask

  task automatic t_mask();
    do_write(3'd4, 32'h0000_0080);
    vec_check("R5 disabled line7", 64'h0000_0000_0010_0080, 8'h00, 8'd20, 1'b1);
    do_write(3'd6, 32'h0000_0001);
    vec_check("R5 disabled core0", 64'd0, 8'h03, 8'd65, 1'b1);
    disable_all();
    vec_check("R5 all disabled", 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 8'd255, 1'b0);
    src_periph = '0; src_core = '0;
  endtask

  task automatic t_timing();
    enable_all();
    @(negedge clk);
    src_periph = 64'h10;
    #2;
    chk("R10 before edge", {23'd0, vec_valid, vec_id}, {23'd0, 1'b0, 8'd255});
    @(negedge clk);
    chk("R10 after edge", {23'd0, vec_valid, vec_id}, {23'd0, 1'b1, 8'd4});
  endtask

  task automatic t_readback();
    src_periph = 64'h0000_0100_0000_0080;
    src_core   = 8'h03;
    rd_check("R11 basic word", 3'd6, 32'h0000_0703);
    rd_check("R11 bank1 pending", 3'd4, 32'h0000_0080);
    rd_check("R11 bank2 pending", 3'd5, 32'h0000_0100);
    rd_check("R11 addr 7 zero", 3'd7, 32'd0);
    src_periph = '0; src_core = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; src_periph = '0; src_core = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cmd_valid = 1'b0; cmd_enable = 1'b0; cmd_vector = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_regs();
    t_cmd();
    t_priority();
    t_mask();
    t_timing();
    t_readback();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule